// File: doc/BRIEF.md
# Status Transfer Sender

This block sits on the physical-layer side of a serial bus and reports link-relevant events to the link controller. It uses a 2-bit control bus and a 2-bit data bus. Four event flags (arbitration reset gap, subaction gap, bus reset, interrupt) collect in a pending set. Register reports come from two places: a small request queue and an automatic report of the physical-ID register after self-identification. Both are packed into a 16-bit status word and shifted out two bits per clock.

A transfer gives way at once to an incoming packet. Flags count as delivered on the beat that carries them. A register report counts as delivered only when its last beat has gone out, so an interrupted report is sent again in full. Transfers are always separated by at least one idle cycle. When the surrounding logic has a bus reset pending, a grant code may follow a complete transfer.

Top module: `sts_sender`

## Requirements
- R1: While `rst` is high at a rising edge, `ctl` and `d` are 00 from the next cycle, and all pending flags and queued requests are cleared.
- R2: Control codes are idle 00, status 01, receive 10, grant 11. A transfer starts (`ctl` goes to 01) only in the cycle after one in which `ctl` was 00, and only if work is pending. The first beat is sent in that same cycle.
- R3: The status word holds the flags in bits 0 to 3, the register address in bits 4 to 7 and the register data in bits 8 to 15. The flags map to `flag_evt` bits 0 to 3: bit 0 is arbitration reset gap, bit 1 subaction gap, bit 2 bus reset and bit 3 interrupt. Word bits {2k+1,2k} appear on `d` on beat k.
- R4: A transfer with no register report lasts 2 beats. A transfer carrying a register report lasts 8 beats. `ctl` stays 01 on every beat.
- R5: When `pkt_rx` is high at an edge, `ctl` is 10 and `d` is 00 in the next cycle, and any transfer in progress is abandoned.
- R6: A flag leaves the pending set on the edge that drives its beat, even if the transfer is later cut short. Flag events arriving at any time are ORed into the pending set.
- R7: A register report is retired only on the edge that drives beat 7. An interrupted report is sent again from beat 0.
- R8: After an interruption, no new transfer starts unless flags are pending or a register report is unretired.
- R9: `ctl` never goes to 01 directly from 10 or 11.
- R10: After the last beat of a complete transfer, `ctl` is 11 for one cycle if `grant_req` is high at that edge, and 00 otherwise. A 00 cycle always follows a 11.
- R11: A `selfid_done` pulse queues a report whose address is PHYID_ADDR and whose data is `physid_val` sampled at the pulse. This report is sent ahead of queued requests.
- R12: Register requests are sent in arrival order. A request that arrives while the queue already holds REQ_DEPTH entries is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_evt | input | 4 | Event pulses: gap, subaction gap, bus reset, interrupt |
| pkt_rx | input | 1 | Incoming packet; forces receive code next cycle |
| grant_req | input | 1 | Bus reset pending; grant after a complete transfer |
| req_valid | input | 1 | Register report request strobe |
| req_addr | input | AW | Register address of the request |
| req_data | input | DW | Register contents of the request |
| selfid_done | input | 1 | Self-identification finished |
| physid_val | input | DW | Physical-ID register value |
| ctl | output | 2 | Control code toward the link |
| d | output | 2 | Status data beat |

## Verification
The bench builds the block with REQ_DEPTH = 2 and PHYID_ADDR = 3. The shallow queue fills after two requests, so the drop rule is reachable from a short burst. The nonzero self-ID address makes the automatic report tell apart from queued requests on the data lines. Directed cases interrupt transfers at the flag beats and at the register beats, and a random soak mixes packets, grants and events against the reference model.

// File: rtl/sts_pkg.sv
package sts_pkg;
  typedef enum logic [1:0] {
    CTL_IDLE = 2'b00,
    CTL_STAT = 2'b01,
    CTL_RX   = 2'b10,
    CTL_GNT  = 2'b11
  } ctl_e;

  localparam int NFLAG = 4;
  localparam int FLAG_BEATS = NFLAG / 2;
endpackage

// File: rtl/sts_req_fifo.sv
module sts_req_fifo #(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          head_valid,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = AW + DW;

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          accept, take;

  assign accept = push && (cnt < CW'(DEPTH));
  assign take   = pop && (cnt != '0);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= {push_addr, push_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (accept) wp <= nxt(wp);
      if (take)   rp <= nxt(rp);
      case ({accept, take})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head_valid = (cnt != '0);
  assign head_addr  = mem[rp][EW-1:DW];
  assign head_data  = mem[rp][DW-1:0];

  // R12: occupancy never passes the configured depth
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  // R12: a push into a full queue with no pop leaves it unchanged
  p_full_drop_r12: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && cnt == CW'(DEPTH)) |=> (cnt == CW'(DEPTH)));
  // R7: retirement only ever targets a stored request
  p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
    pop |-> head_valid);
endmodule

// File: rtl/sts_flag_track.sv
module sts_flag_track
  import sts_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] evt,
  input  logic [NFLAG-1:0] clr,
  output logic [NFLAG-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr) | evt;
  end

  // R6: a flag sent with no fresh event is gone next cycle
  p_sent_cleared_r6: assert property (@(posedge clk) disable iff (rst)
    ((clr & ~evt) != '0) |=> ((pend & $past(clr & ~evt)) == '0));
  // R6: a fresh event is always recorded
  p_evt_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));
endmodule

// File: rtl/sts_reg_src.sv
module sts_reg_src #(
  parameter int          AW         = 4,
  parameter int          DW         = 8,
  parameter int          REQ_DEPTH  = 4,
  parameter logic [AW-1:0] PHYID_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          selfid_done,
  input  logic [DW-1:0] physid_val,
  input  logic          retire_sid,
  input  logic          retire_q,
  output logic          has_reg,
  output logic          is_sid,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_data
);
  logic          sid_pend;
  logic [DW-1:0] sid_data;
  logic          q_valid;
  logic [AW-1:0] q_addr;
  logic [DW-1:0] q_data;

  sts_req_fifo #(.AW(AW), .DW(DW), .DEPTH(REQ_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (req_valid),
    .push_addr (req_addr),
    .push_data (req_data),
    .pop       (retire_q),
    .head_valid(q_valid),
    .head_addr (q_addr),
    .head_data (q_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sid_pend <= 1'b0;
      sid_data <= '0;
    end else begin
      sid_pend <= selfid_done | (sid_pend & ~retire_sid);
      if (selfid_done) sid_data <= physid_val;
    end
  end

  assign has_reg  = sid_pend | q_valid;
  assign is_sid   = sid_pend;
  assign reg_addr = sid_pend ? PHYID_ADDR : q_addr;
  assign reg_data = sid_pend ? sid_data : q_data;

  // R11: the self-ID report is retired only while it is pending
  p_sid_retire_r11: assert property (@(posedge clk) disable iff (rst)
    retire_sid |-> sid_pend);
  // R11: a self-ID pulse always leaves a report pending
  p_sid_armed_r11: assert property (@(posedge clk) disable iff (rst)
    selfid_done |=> sid_pend);
endmodule

// File: rtl/sts_tx_seq.sv
module sts_tx_seq
  import sts_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_rx,
  input  logic             grant_req,
  input  logic [NFLAG-1:0] pend,
  input  logic             has_reg,
  input  logic             is_sid,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_data,
  output logic [NFLAG-1:0] clr,
  output logic             retire_sid,
  output logic             retire_q,
  output logic [1:0]       ctl,
  output logic [1:0]       d
);
  localparam int WW         = NFLAG + AW + DW;
  localparam int LONG_BEATS = WW / 2;
  localparam int BW         = $clog2(LONG_BEATS + 1);

  ctl_e          ctl_q, ctl_n;
  logic [1:0]    d_q, d_n;
  logic          act_q, act_n;
  logic          long_q, long_n;
  logic          sid_q, sid_n;
  logic [BW-1:0] nb_q, nb_n;
  logic [WW-1:0] word_q, word_n;
  logic [BW-1:0] blen;
  logic [NFLAG-1:0] bmask;

  assign blen  = long_q ? BW'(LONG_BEATS) : BW'(FLAG_BEATS);
  assign bmask = NFLAG'(2'b11) << (2 * nb_q);

  always_comb begin
    ctl_n      = CTL_IDLE;
    d_n        = 2'b00;
    act_n      = act_q;
    long_n     = long_q;
    sid_n      = sid_q;
    nb_n       = nb_q;
    word_n     = word_q;
    clr        = '0;
    retire_sid = 1'b0;
    retire_q   = 1'b0;
    if (pkt_rx) begin
      ctl_n = CTL_RX;
      act_n = 1'b0;
    end else if (act_q && nb_q < blen) begin
      ctl_n = CTL_STAT;
      d_n   = word_q[2*int'(nb_q) +: 2];
      nb_n  = nb_q + 1'b1;
      clr   = word_q[NFLAG-1:0] & bmask;
      if (long_q && nb_q == BW'(LONG_BEATS - 1)) begin
        retire_sid = sid_q;
        retire_q   = ~sid_q;
      end
    end else if (act_q) begin
      ctl_n = grant_req ? CTL_GNT : CTL_IDLE;
      act_n = 1'b0;
    end else if (ctl_q == CTL_IDLE && (pend != '0 || has_reg)) begin
      word_n = has_reg ? {reg_data, reg_addr, pend} : {{(AW+DW){1'b0}}, pend};
      long_n = has_reg;
      sid_n  = is_sid;
      ctl_n  = CTL_STAT;
      d_n    = pend[1:0];
      clr    = pend & NFLAG'(2'b11);
      nb_n   = BW'(1);
      act_n  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= CTL_IDLE;
      d_q    <= 2'b00;
      act_q  <= 1'b0;
      long_q <= 1'b0;
      sid_q  <= 1'b0;
      nb_q   <= '0;
      word_q <= '0;
    end else begin
      ctl_q  <= ctl_n;
      d_q    <= d_n;
      act_q  <= act_n;
      long_q <= long_n;
      sid_q  <= sid_n;
      nb_q   <= nb_n;
      word_q <= word_n;
    end
  end

  assign ctl = ctl_q;
  assign d   = d_q;

  // R5: a packet always takes the bus on the next cycle
  p_rx_wins_r5: assert property (@(posedge clk) disable iff (rst)
    pkt_rx |=> (ctl_q == CTL_RX));
  // R9: no status beat directly after receive or grant
  p_gap_r9: assert property (@(posedge clk) disable iff (rst)
    (ctl_q == CTL_RX || ctl_q == CTL_GNT) |=> (ctl_q != CTL_STAT));
  // R10: a grant lasts a single cycle and is followed by idle unless a packet comes
  p_grant_once_r10: assert property (@(posedge clk) disable iff (rst)
    (ctl_q == CTL_GNT && !pkt_rx) |=> (ctl_q == CTL_IDLE));
  // R4: the beat counter never runs past the transfer length
  p_len_r4: assert property (@(posedge clk) disable iff (rst)
    act_q |-> (nb_q <= blen));
  // R7: retirement happens only while driving a status beat
  p_retire_on_beat_r7: assert property (@(posedge clk) disable iff (rst)
    (retire_sid || retire_q) |=> (ctl_q == CTL_STAT));
endmodule

// File: rtl/sts_sender.sv
module sts_sender
  import sts_pkg::*;
#(
  parameter int            AW         = 4,
  parameter int            DW         = 8,
  parameter int            REQ_DEPTH  = 4,
  parameter logic [AW-1:0] PHYID_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    flag_evt,
  input  logic          pkt_rx,
  input  logic          grant_req,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          selfid_done,
  input  logic [DW-1:0] physid_val,
  output logic [1:0]    ctl,
  output logic [1:0]    d
);
  logic [NFLAG-1:0] pend, clr;
  logic             has_reg, is_sid, retire_sid, retire_q;
  logic [AW-1:0]    reg_addr;
  logic [DW-1:0]    reg_data;

  sts_flag_track u_flags (
    .clk (clk),
    .rst (rst),
    .evt (flag_evt),
    .clr (clr),
    .pend(pend)
  );

  sts_reg_src #(
    .AW(AW), .DW(DW), .REQ_DEPTH(REQ_DEPTH), .PHYID_ADDR(PHYID_ADDR)
  ) u_src (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .selfid_done(selfid_done),
    .physid_val (physid_val),
    .retire_sid (retire_sid),
    .retire_q   (retire_q),
    .has_reg    (has_reg),
    .is_sid     (is_sid),
    .reg_addr   (reg_addr),
    .reg_data   (reg_data)
  );

  sts_tx_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .pkt_rx    (pkt_rx),
    .grant_req (grant_req),
    .pend      (pend),
    .has_reg   (has_reg),
    .is_sid    (is_sid),
    .reg_addr  (reg_addr),
    .reg_data  (reg_data),
    .clr       (clr),
    .retire_sid(retire_sid),
    .retire_q  (retire_q),
    .ctl       (ctl),
    .d         (d)
  );

  // R1: the cycle after a reset edge shows idle
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (ctl == 2'b00 && d == 2'b00));
endmodule

// File: tb/sim_sts_sender.sv
`timescale 1ns/1ps
module sim_sts_sender;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 2;
  localparam logic [3:0] PID = 4'h3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic [3:0] flag_evt = '0;
  logic pkt_rx = 1'b0, grant_req = 1'b0, req_valid = 1'b0, selfid_done = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0, physid_val = '0;
  logic [1:0] ctl, d;

  sts_sender #(.AW(AW), .DW(DW), .REQ_DEPTH(DEPTH), .PHYID_ADDR(PID)) u0 (
    .clk(clk), .rst(rst), .flag_evt(flag_evt), .pkt_rx(pkt_rx),
    .grant_req(grant_req), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .selfid_done(selfid_done), .physid_val(physid_val),
    .ctl(ctl), .d(d)
  );

  int checks = 0, fails = 0;
  string tag = "R1";
  bit started = 0, done = 0;
  int prev_ctl = 0;

  // reference model state
  int m_ctl = 0, m_d = 0, pend = 0, sid_d = 0, nb = 0, len = 0, word = 0;
  bit sid_p = 0, act = 0, srcsid = 0;
  int q[$];

  always @(posedge clk) begin : model
    int nctl, nd, clrm, a, dd;
    bit full, ret_s, ret_q, r;
    started <= 1'b1;
    if (rst) begin
      m_ctl = 0; m_d = 0; pend = 0; sid_p = 0; sid_d = 0; act = 0; nb = 0;
      len = 0; word = 0; srcsid = 0; q.delete();
    end else begin
      clrm = 0; ret_s = 0; ret_q = 0; nctl = 0; nd = 0;
      full = (q.size() >= DEPTH);
      if (pkt_rx) begin
        nctl = 2; act = 0;
      end else if (act && nb < len) begin
        nctl = 1;
        nd = (word >> (2 * nb)) & 3;
        if (nb < 2) clrm = (word & 15) & (3 << (2 * nb));
        nb++;
        if (len == 8 && nb == 8) begin
          if (srcsid) ret_s = 1; else ret_q = 1;
        end
      end else if (act) begin
        nctl = grant_req ? 3 : 0; act = 0;
      end else if (m_ctl == 0 && (pend != 0 || sid_p || q.size() > 0)) begin
        r = 1; a = 0; dd = 0;
        if (sid_p) begin a = PID; dd = sid_d; srcsid = 1; end
        else if (q.size() > 0) begin a = q[0] >> 8; dd = q[0] & 255; srcsid = 0; end
        else r = 0;
        word = pend | (a << 4) | (dd << 8);
        len = r ? 8 : 2; act = 1; nctl = 1; nd = pend & 3; clrm = pend & 3; nb = 1;
      end
      pend = (pend & ~clrm) | int'(flag_evt);
      if (ret_q) void'(q.pop_front());
      if (req_valid && !full) q.push_back((int'(req_addr) << 8) | int'(req_data));
      sid_p = selfid_done | (sid_p & !ret_s);
      if (selfid_done) sid_d = int'(physid_val);
      m_ctl = nctl; m_d = nd;
    end
  end

  always @(negedge clk) begin : compare
    if (started && !done) begin
      checks++;
      if (ctl !== m_ctl[1:0] || d !== m_d[1:0]) begin
        fails++;
        $display("FAIL %s t=%0t ctl/d actual %b/%b expected %b/%b", tag, $time, ctl, d,
                 m_ctl[1:0], m_d[1:0]);
      end
      // R9: status never directly after receive or grant
      checks++;
      if (!rst && ctl == 2'b01 && (prev_ctl == 2 || prev_ctl == 3)) begin
        fails++;
        $display("FAIL R9 ctl actual 01 after %0d expected 00 gap", prev_ctl);
      end
      prev_ctl = int'(ctl);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_flags(logic [3:0] v);
    flag_evt = v; step(); flag_evt = '0;
  endtask

  task automatic push_req(logic [3:0] a, logic [7:0] v);
    req_valid = 1'b1; req_addr = a; req_data = v; step(); req_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int n01;
    step(3);
    tag = "R1"; rst = 1'b0; step(4);
    tag = "R2"; pulse_flags(4'b0001); step(6);
    tag = "R3"; pulse_flags(4'b1010); step(6);
    tag = "R4"; push_req(4'h5, 8'hC6); step(14);
    tag = "R6"; pulse_flags(4'b1111); flag_evt = 4'b0100; step(); flag_evt = '0; step(10);
    tag = "R10"; grant_req = 1'b1; pulse_flags(4'b0100); step(6); grant_req = 1'b0; step(3);
    tag = "R7"; push_req(4'h9, 8'h3B); step(4); pkt_rx = 1'b1; step(3); pkt_rx = 1'b0; step(16);
    tag = "R5"; pulse_flags(4'b1100); step(1); pkt_rx = 1'b1; step(2); pkt_rx = 1'b0; step(8);
    // R8: only beat-0 flags pending; cut after beat 0, nothing must follow
    tag = "R8"; pulse_flags(4'b0011); step(1); pkt_rx = 1'b1; step(2); pkt_rx = 1'b0;
    n01 = 0;
    for (int i = 0; i < 10; i++) begin step(); if (ctl == 2'b01) n01++; end
    checks++;
    if (n01 != 0) begin fails++; $display("FAIL R8 retry beats actual %0d expected 0", n01); end
    tag = "R11"; push_req(4'h2, 8'h11); physid_val = 8'h5A; selfid_done = 1'b1; step();
    selfid_done = 1'b0; step(30);
    tag = "R12"; push_req(4'h1, 8'hA1); push_req(4'h2, 8'hA2); push_req(4'h4, 8'hA4);
    push_req(4'h8, 8'hA8); step(40);
    tag = "R9";
    for (int i = 0; i < 4000; i++) begin
      flag_evt    = (($urandom % 8) == 0) ? 4'($urandom) : 4'b0;
      pkt_rx      = (($urandom % 10) < 2);
      grant_req   = (($urandom % 3) == 0);
      req_valid   = (($urandom % 12) == 0);
      req_addr    = 4'($urandom);
      req_data    = 8'($urandom);
      selfid_done = (($urandom % 200) == 0);
      physid_val  = 8'($urandom);
      step();
    end
    flag_evt = '0; pkt_rx = 0; grant_req = 0; req_valid = 0; selfid_done = 0;
    step(40);
    tag = "R1"; rst = 1'b1; pulse_flags(4'b1111); step(2); rst = 1'b0; step(6);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule